// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt request pulses from up to 32 peripheral and external sources on behalf of a small processor core. Every source owns a sticky pending flag, an enable bit and a 3-bit priority. Each cycle the block picks one winner among the sources that are pending, enabled and have a non-zero priority. It raises a request to the core only when that winner's priority is strictly above the effective CPU level. The request carries a 7-bit vector number and a 4-bit level, and both are also kept in a readable status word.

The core answers with an acknowledge pulse, which moves the CPU level up to the presented level and saves the old level on a small stack. A return pulse brings the saved level back. Software sees a simple 32-bit word bus (write enable, word address, write data, registered read data). Through it software clears flags, sets enables and priorities, writes the low bits of the CPU level and sets a control bit that stops nested preemption.

Top module: `irq_vec_ctrl`

## Requirements
- R1: A high `src_i[i]` sets pending flag i at the next edge. The flag stays set until a write to word 0 with data bit i = 1 clears it. Writing 0 to a bit leaves it alone. If a set and a clear of the same bit fall in the same cycle, the flag ends up set.
- R2: A source takes part in arbitration only if its flag is set, its enable bit (word 1, bit i) is set and its priority is non-zero. Priority 0 disables the source.
- R3: Source i's priority sits at word 2 + i/8, bits 4*(i%8)+2 down to 4*(i%8), so source 0 uses bits 2:0 of word 2. Flag and enable bits sit at bit i. Words 2 to 5 read back what was written, with the unused bit of each 4-bit slot reading 0.
- R4: Among eligible sources the highest priority wins. When priorities are equal, the lowest source index wins.
- R5: `irq_o` is presented two edges after the source pulse. `vec_o` = 8 + winner index, and `lvl_o` = {0, winner priority}.
- R6: A request is raised only when the winner's level is strictly greater than the effective CPU level.
- R7: The CPU level reads at word 9. A write there sets bits 2:0 only, and bit 3 cannot be set by software.
- R8: An acknowledge while `irq_o` is high sets the CPU level to `lvl_o`, saves the old level and drops `irq_o` at that edge. A return restores the most recently saved level. A return with nothing saved is ignored.
- R9: While word 8 bit 0 (nesting disable) is set and at least one acknowledged interrupt has not returned, no request is raised, whatever the priority.
- R10: Word 10 reads the vector in bits 6:0 and the level in bits 11:8 of the latest raised request, and holds them afterwards.
- R11: Read data is registered: `rdata_o` shows the word addressed in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Interrupt request pulses, one per source |
| we_i | input | 1 | Register write enable |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Registered read data |
| ack_i | input | 1 | Core acknowledge of the presented request |
| ret_i | input | 1 | Core return from the current interrupt |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | 7 | Vector number of the presented request |
| lvl_o | output | 4 | Level of the presented request |

## Verification
The hardest situation to reach is a higher-priority request arriving while a lower one is in service. It must behave one way with nesting disabled and another way with it enabled, and the level saved on acknowledge must then come back correctly on return. The bench gets there with a scripted chain. It pends a priority-4 source and acknowledges it, then pends a priority-6 source. It checks preemption, acknowledges again and returns twice, and after each step it reads the CPU level back over the bus. It then repeats the chain with the nesting-disable bit set. Arbitration itself is swept over every source alone, over several computed priority and enable patterns, and over every pairing of priority and CPU level.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int REG_AW = 4;
  typedef logic [REG_AW-1:0] reg_addr_t;

  localparam reg_addr_t A_FLAG  = 4'd0;
  localparam reg_addr_t A_EN    = 4'd1;
  localparam reg_addr_t A_PRIO0 = 4'd2;
  localparam reg_addr_t A_CTRL  = 4'd8;
  localparam reg_addr_t A_LVL   = 4'd9;
  localparam reg_addr_t A_STAT  = 4'd10;

  localparam int SLOT_W         = 4;
  localparam int SLOTS_PER_WORD = 8;
  localparam int STAT_LVL_LSB   = 8;
endpackage

// File: rtl/ivc_regs.sv
module ivc_regs
  import ivc_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 3,
  parameter int LVL_W  = 4,
  parameter int VEC_W  = 7
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NSRC-1:0]              src_i,
  input  logic                         we_i,
  input  reg_addr_t                    addr_i,
  input  logic [31:0]                  wdata_i,
  input  logic [LVL_W-1:0]             cpu_lvl_i,
  input  logic [LVL_W-1:0]             stat_lvl_i,
  input  logic [VEC_W-1:0]             stat_vec_i,
  output logic [NSRC-1:0]              flags_o,
  output logic [NSRC-1:0]              en_o,
  output logic [NSRC-1:0][PRIO_W-1:0]  prio_o,
  output logic                         nest_dis_o,
  output logic                         lvl_we_o,
  output logic [31:0]                  rdata_o
);
  logic [NSRC-1:0]             flags_q, en_q, clr;
  logic [NSRC-1:0][PRIO_W-1:0] prio_q;
  logic                        nest_q;
  logic [31:0]                 rd_n, rd_q;
  logic                        we_flag, we_en, we_ctrl;

  assign we_flag  = we_i && (addr_i == A_FLAG);
  assign we_en    = we_i && (addr_i == A_EN);
  assign we_ctrl  = we_i && (addr_i == A_CTRL);
  assign lvl_we_o = we_i && (addr_i == A_LVL);
  assign clr      = we_flag ? wdata_i[NSRC-1:0] : '0;

  // set beats clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= (flags_q & ~clr) | src_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      nest_q <= 1'b0;
    end else begin
      if (we_en)   en_q   <= wdata_i[NSRC-1:0];
      if (we_ctrl) nest_q <= wdata_i[0];
    end
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_prio
    localparam int WORD = s / SLOTS_PER_WORD;
    localparam int SLOT = s % SLOTS_PER_WORD;
    always_ff @(posedge clk) begin
      if (rst)
        prio_q[s] <= '0;
      else if (we_i && (addr_i == reg_addr_t'(int'(A_PRIO0) + WORD)))
        prio_q[s] <= wdata_i[SLOT*SLOT_W +: PRIO_W];
    end
  end

  always_comb begin
    rd_n = '0;
    case (addr_i)
      A_FLAG: rd_n[NSRC-1:0] = flags_q;
      A_EN:   rd_n[NSRC-1:0] = en_q;
      A_CTRL: rd_n[0]        = nest_q;
      A_LVL:  rd_n[LVL_W-1:0] = cpu_lvl_i;
      A_STAT: begin
        rd_n[VEC_W-1:0]              = stat_vec_i;
        rd_n[STAT_LVL_LSB +: LVL_W]  = stat_lvl_i;
      end
      default: begin
        for (int s = 0; s < NSRC; s++)
          if (int'(addr_i) == int'(A_PRIO0) + s / SLOTS_PER_WORD)
            rd_n[(s % SLOTS_PER_WORD)*SLOT_W +: PRIO_W] = prio_q[s];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_n;
  end

  assign flags_o    = flags_q;
  assign en_o       = en_q;
  assign prio_o     = prio_q;
  assign nest_dis_o = nest_q;
  assign rdata_o    = rd_q;

  p_flag_sticky_r1: assert property (@(posedge clk) disable iff (rst)
    !we_flag |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  p_set_wins_r1: assert property (@(posedge clk) disable iff (rst)
    (|src_i) |=> ((flags_q & $past(src_i)) == $past(src_i)));

  p_read_reg_r11: assert property (@(posedge clk) disable iff (rst)
    (we_en && addr_i == A_EN) |=> (en_q == $past(wdata_i[NSRC-1:0])));
endmodule

// File: rtl/ivc_arb.sv
module ivc_arb #(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 3,
  parameter int IDX_W  = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]             flags_i,
  input  logic [NSRC-1:0]             en_i,
  input  logic [NSRC-1:0][PRIO_W-1:0] prio_i,
  output logic                        win_v_o,
  output logic [IDX_W-1:0]            win_idx_o,
  output logic [PRIO_W-1:0]           win_prio_o
);
  logic [NSRC-1:0] elig;

  for (genvar s = 0; s < NSRC; s++) begin : g_elig
    assign elig[s] = flags_i[s] & en_i[s] & (|prio_i[s]);
  end

  // scan downwards; ">=" lets the lower index take a tie
  always_comb begin
    win_v_o    = 1'b0;
    win_idx_o  = '0;
    win_prio_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i] && (!win_v_o || prio_i[i] >= win_prio_o)) begin
        win_v_o    = 1'b1;
        win_idx_o  = IDX_W'(i);
        win_prio_o = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/ivc_lvl.sv
module ivc_lvl #(
  parameter int LVL_W = 4,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_we_i,
  input  logic [LVL_W-2:0] sw_data_i,
  input  logic             ack_i,
  input  logic [LVL_W-1:0] ack_lvl_i,
  input  logic             ret_i,
  input  logic             nest_dis_i,
  output logic [LVL_W-1:0] cpu_lvl_o,
  output logic [LVL_W-1:0] eff_lvl_o,
  output logic             in_svc_o
);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int IW  = $clog2(DEPTH);
  localparam logic [LVL_W-1:0] NEST_LVL = {1'b0, {(LVL_W-1){1'b1}}};

  logic [LVL_W-1:0] stk [DEPTH];
  logic [SPW-1:0]   sp_q, spm1;
  logic [LVL_W-1:0] cpu_q;
  logic             push, pop;

  assign spm1 = sp_q - 1'b1;
  assign push = ack_i && (sp_q != SPW'(DEPTH));
  assign pop  = !ack_i && ret_i && (sp_q != '0);

  always_ff @(posedge clk) begin
    if (push) stk[sp_q[IW-1:0]] <= cpu_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q  <= '0;
      cpu_q <= '0;
    end else if (push) begin
      sp_q  <= sp_q + 1'b1;
      cpu_q <= ack_lvl_i;
    end else if (pop) begin
      sp_q  <= spm1;
      cpu_q <= stk[spm1[IW-1:0]];
    end else if (sw_we_i) begin
      cpu_q <= {cpu_q[LVL_W-1], sw_data_i};
    end
  end

  assign in_svc_o  = (sp_q != '0);
  assign cpu_lvl_o = cpu_q;
  assign eff_lvl_o = (nest_dis_i && in_svc_o) ? NEST_LVL : cpu_q;

  p_sw_low_bits_r7: assert property (@(posedge clk) disable iff (rst)
    (sw_we_i && !ack_i && !ret_i) |=>
      (cpu_q == {$past(cpu_q[LVL_W-1]), $past(sw_data_i)}));

  p_ack_takes_lvl_r8: assert property (@(posedge clk) disable iff (rst)
    push |=> (cpu_q == $past(ack_lvl_i)));

  p_ret_pops_r8: assert property (@(posedge clk) disable iff (rst)
    (ret_i && !ack_i && sp_q != '0) |=> (sp_q == $past(spm1)));
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import ivc_pkg::*;
#(
  parameter int NSRC       = 32,
  parameter int PRIO_W     = 3,
  parameter int VEC_W      = 7,
  parameter int LVL_W      = 4,
  parameter int VEC_BASE   = 8,
  parameter int NEST_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              ack_i,
  input  logic              ret_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [LVL_W-1:0]  lvl_o
);
  localparam int IDX_W = $clog2(NSRC);

  logic [NSRC-1:0]             flags, en;
  logic [NSRC-1:0][PRIO_W-1:0] prio;
  logic                        nest_dis, lvl_we;
  logic                        win_v;
  logic [IDX_W-1:0]            win_idx;
  logic [PRIO_W-1:0]           win_prio;
  logic [LVL_W-1:0]            cpu_lvl, eff_lvl, win_lvl;
  logic                        in_svc, req, ack_ok;
  logic                        irq_q;
  logic [VEC_W-1:0]            vec_q;
  logic [LVL_W-1:0]            lvl_q;

  ivc_regs #(.NSRC(NSRC), .PRIO_W(PRIO_W), .LVL_W(LVL_W), .VEC_W(VEC_W)) u_regs (
    .clk(clk), .rst(rst), .src_i(src_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .cpu_lvl_i(cpu_lvl), .stat_lvl_i(lvl_q), .stat_vec_i(vec_q),
    .flags_o(flags), .en_o(en), .prio_o(prio), .nest_dis_o(nest_dis),
    .lvl_we_o(lvl_we), .rdata_o(rdata_o)
  );

  ivc_arb #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
    .flags_i(flags), .en_i(en), .prio_i(prio),
    .win_v_o(win_v), .win_idx_o(win_idx), .win_prio_o(win_prio)
  );

  assign ack_ok = ack_i && irq_q;

  ivc_lvl #(.LVL_W(LVL_W), .DEPTH(NEST_DEPTH)) u_lvl (
    .clk(clk), .rst(rst), .sw_we_i(lvl_we), .sw_data_i(wdata_i[LVL_W-2:0]),
    .ack_i(ack_ok), .ack_lvl_i(lvl_q), .ret_i(ret_i), .nest_dis_i(nest_dis),
    .cpu_lvl_o(cpu_lvl), .eff_lvl_o(eff_lvl), .in_svc_o(in_svc)
  );

  assign win_lvl = LVL_W'(win_prio);
  assign req     = win_v && (win_lvl > eff_lvl);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      vec_q <= '0;
      lvl_q <= '0;
    end else begin
      irq_q <= req && !ack_ok;
      if (req) begin
        vec_q <= VEC_W'(VEC_BASE) + VEC_W'(win_idx);
        lvl_q <= win_lvl;
      end
    end
  end

  assign irq_o = irq_q;
  assign vec_o = vec_q;
  assign lvl_o = lvl_q;

  p_win_eligible_r2: assert property (@(posedge clk) disable iff (rst)
    win_v |-> (flags[win_idx] && en[win_idx] && prio[win_idx] != '0));

  p_vec_range_r5: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (vec_q >= VEC_W'(VEC_BASE) && vec_q < VEC_W'(VEC_BASE + NSRC)));

  p_strictly_above_r6: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (lvl_q > $past(eff_lvl)));

  p_ack_drops_r8: assert property (@(posedge clk) disable iff (rst)
    ack_ok |=> !irq_q);

  p_no_nesting_r9: assert property (@(posedge clk) disable iff (rst)
    (nest_dis && in_svc) |=> !irq_q);
endmodule

// File: tb/irq_vec_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vec_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src = '0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ack = 1'b0, ret = 1'b0;
  logic        irq;
  logic [6:0]  vec;
  logic [3:0]  lvl;

  int ncmp = 0, nbad = 0;
  bit done = 1'b0;
  int pr_sh [32];
  logic [31:0] en_sh;

  always #5 clk = ~clk;

  irq_vec_ctrl u_dut (
    .clk(clk), .rst(rst), .src_i(src), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ack_i(ack), .ret_i(ret),
    .irq_o(irq), .vec_o(vec), .lvl_o(lvl)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    ncmp++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic pulse(input logic [31:0] m);
    @(negedge clk); src = m;
    @(negedge clk); src = '0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic do_ret();
    @(negedge clk); ret = 1'b1;
    @(negedge clk); ret = 1'b0;
  endtask

  function automatic logic [31:0] pword(input int k);
    logic [31:0] w = '0;
    for (int j = 0; j < 8; j++) w[4*j +: 3] = pr_sh[8*k + j][2:0];
    return w;
  endfunction

  task automatic load_prio();
    for (int k = 0; k < 4; k++) wr(4'(2 + k), pword(k));
  endtask

  function automatic int winner(input logic [31:0] fl, input logic [31:0] en_m);
    int best = -1;
    int bp = 0;
    for (int i = 0; i < 32; i++)
      if (fl[i] && en_m[i] && pr_sh[i] > bp) begin best = i; bp = pr_sh[i]; end
    return best;
  endfunction

  task automatic clear_all();
    wr(4'd0, 32'hFFFF_FFFF);
    wr(4'd1, 32'h0);
    wr(4'd8, 32'h0);
    wr(4'd9, 32'h0);
    for (int i = 0; i < 32; i++) pr_sh[i] = 0;
    load_prio();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    chk("R5 irq after reset", {31'b0, irq}, 32'h0);
    rd(4'd10, d); chk("R10 status after reset", d, 32'h0);
    rd(4'd0, d);  chk("R1 flags after reset", d, 32'h0);
    rd(4'd9, d);  chk("R7 level after reset", d, 32'h0);

    // R1: sticky flags, write-one-to-clear, set wins
    pulse(32'h1 << 5); settle();
    rd(4'd0, d); chk("R1 flag held", d, 32'h20);
    wr(4'd0, 32'h10);
    rd(4'd0, d); chk("R1 clear of other bit", d, 32'h20);
    wr(4'd0, 32'h20);
    rd(4'd0, d); chk("R1 clear own bit", d, 32'h0);
    @(negedge clk); we = 1'b1; addr = 4'd0; wdata = 32'h200; src = 32'h200;
    @(negedge clk); we = 1'b0; src = '0;
    rd(4'd0, d); chk("R1 set beats clear", d, 32'h200);
    clear_all();

    // R3: priority layout readback
    for (int i = 0; i < 32; i++) pr_sh[i] = (i % 7) + 1;
    load_prio();
    for (int k = 0; k < 4; k++) begin
      rd(4'(2 + k), d); chk($sformatf("R3 prio word %0d", k), d, pword(k));
    end

    // R2: nothing enabled -> no request
    pulse(32'hFFFF_FFFF); settle();
    chk("R2 no enable no irq", {31'b0, irq}, 32'h0);
    rd(4'd0, d); chk("R1 all flags set", d, 32'hFFFF_FFFF);

    // R5/R3: each source alone
    for (int i = 0; i < 32; i++) begin
      wr(4'd1, 32'h1 << i); settle();
      chk($sformatf("R5 irq src %0d", i), {31'b0, irq}, 32'h1);
      chk($sformatf("R5 vec src %0d", i), {25'b0, vec}, 32'(8 + i));
      chk($sformatf("R5 lvl src %0d", i), {28'b0, lvl}, 32'(pr_sh[i]));
      rd(4'd10, d);
      chk($sformatf("R10 status src %0d", i), d, 32'((pr_sh[i] << 8) | (8 + i)));
    end

    // R2: priority zero disables
    pr_sh[2] = 0; load_prio();
    wr(4'd1, 32'h4); settle();
    chk("R2 prio zero no irq", {31'b0, irq}, 32'h0);
    rd(4'd10, d); chk("R10 status holds", d, 32'((pr_sh[31] << 8) | 39));

    // R4: arbitration patterns
    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < 32; i++) pr_sh[i] = (i * (2 * k + 1) + k) % 8;
      if (k == 7) for (int i = 0; i < 32; i++) pr_sh[i] = 5;
      load_prio();
      en_sh = (k == 6) ? 32'hFFFF_0000 : (32'hFFFF_FFFF ^ (32'h1 << (k * 3)));
      wr(4'd1, en_sh); settle();
      w = winner(32'hFFFF_FFFF, en_sh);
      chk($sformatf("R4 irq pattern %0d", k), {31'b0, irq}, (w >= 0) ? 32'h1 : 32'h0);
      chk($sformatf("R4 vec pattern %0d", k), {25'b0, vec}, 32'(8 + w));
      chk($sformatf("R4 lvl pattern %0d", k), {28'b0, lvl}, 32'(pr_sh[w]));
    end
    clear_all();

    // R6: strictly-greater sweep over priority and CPU level
    pulse(32'h1); wr(4'd1, 32'h1);
    for (int p = 1; p < 8; p++) begin
      pr_sh[0] = p; wr(4'd2, pword(0));
      for (int l = 0; l < 8; l++) begin
        wr(4'd9, 32'(l)); settle();
        chk($sformatf("R6 p=%0d l=%0d", p, l), {31'b0, irq}, (p > l) ? 32'h1 : 32'h0);
      end
    end

    // R7: top bit of level not writable
    wr(4'd9, 32'hF);
    rd(4'd9, d); chk("R7 top bit read-only", d, 32'h7);
    clear_all();

    // R8/R9: acknowledge, preemption, return, nesting disable
    pr_sh[3] = 4; pr_sh[7] = 6; load_prio();
    wr(4'd1, 32'h88);
    pulse(32'h8); settle();
    chk("R5 irq src3", {31'b0, irq}, 32'h1);
    chk("R5 vec src3", {25'b0, vec}, 32'd11);
    do_ack();
    chk("R8 irq drops on ack", {31'b0, irq}, 32'h0);
    settle();
    rd(4'd9, d); chk("R8 level after ack", d, 32'h4);
    chk("R6 equal level no irq", {31'b0, irq}, 32'h0);
    pulse(32'h80); settle();
    chk("R9 preempt allowed", {31'b0, irq}, 32'h1);
    chk("R4 preempt vec", {25'b0, vec}, 32'd15);
    do_ack();
    rd(4'd9, d); chk("R8 level after 2nd ack", d, 32'h6);
    do_ret();
    rd(4'd9, d); chk("R8 level restored", d, 32'h4);
    settle();
    chk("R8 src7 again after ret", {31'b0, irq}, 32'h1);
    wr(4'd0, 32'h80); settle();
    chk("R6 src3 not above 4", {31'b0, irq}, 32'h0);
    do_ret(); settle();
    rd(4'd9, d); chk("R8 level back to 0", d, 32'h0);
    chk("R8 src3 after ret", {31'b0, irq}, 32'h1);
    chk("R8 src3 vec after ret", {25'b0, vec}, 32'd11);
    wr(4'd8, 32'h1); settle();
    chk("R9 idle not blocked", {31'b0, irq}, 32'h1);
    do_ack(); settle();
    pulse(32'h80); settle();
    chk("R9 nesting blocked", {31'b0, irq}, 32'h0);
    do_ret(); settle();
    chk("R9 irq after ret", {31'b0, irq}, 32'h1);
    chk("R9 vec after ret", {25'b0, vec}, 32'd15);
    chk("R9 lvl after ret", {28'b0, lvl}, 32'd6);
    wr(4'd9, 32'h3);
    do_ret();
    rd(4'd9, d); chk("R8 empty ret ignored", d, 32'h3);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end
endmodule